// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Watermarks and Fall-Through Read

This block is a single-clock first-in first-out queue. Words written with the write enable are held in an inferred two-port memory. The write and read addresses advance by themselves on every accepted operation. Words leave the queue in the order they arrived. The write and read ports carry words of the same width. Besides full and empty, the block drives two watermark flags. Their levels come from two inputs that may change at any cycle, so software or a neighbouring controller can move them at run time.

A mode input selects one of two read behaviours. In standard mode, a read request returns its word one clock later, together with a one-cycle valid pulse. In fall-through mode, the oldest stored word is always presented on the read data port, with valid high, as soon as it is stored and without any read request. A read request then acknowledges that word and pops it. After the first word has been consumed, the two modes move data through the queue in the same way. The mode input is expected to change only while reset is held.

Top module: `sfifo_top`

## Requirements
- R1: A synchronous reset, held high over a rising edge, empties the queue. Afterwards empty and almost_empty are 1, full is 0, rd_valid is 0 and rd_data is 0, in both modes.
- R2: Every word accepted at the write port is returned exactly once, unchanged, and in write order, including across many wraps of the internal addresses.
- R3: full is 1 exactly when DEPTH words are stored. A write request while full is dropped: the stored words, the flags and the data later read back are the same as if the request had not been made.
- R4: empty is 1 exactly when no word is stored. A read request while empty is dropped: the flags, rd_valid and rd_data are the same as if the request had not been made.
- R5: In standard mode, a read accepted at a rising edge makes rd_valid 1 for the following cycle, with the popped word on rd_data. In any other cycle rd_valid is 0, and rd_data holds its last value.
- R6: In fall-through mode, rd_valid equals not-empty and rd_data shows the oldest stored word without a read request, starting in the cycle after it is written. rd_data is 0 while empty. An accepted read pops the shown word, and the next word appears in the following cycle.
- R7: almost_full is 1 exactly when occupancy + af_level >= DEPTH. It is therefore 1 whenever full is 1, and it is 1 in every cycle when af_level >= DEPTH.
- R8: almost_empty is 1 exactly when occupancy <= ae_level. It is therefore 1 whenever empty is 1, and with ae_level = 0 it is 1 only when empty.
- R9: A write and a read in the same cycle on a queue that is neither empty nor full both take effect, and the occupancy is unchanged. The same request on a full queue pops one word and drops the write. On an empty queue it stores the word and drops the read.
- R10: A change on af_level or ae_level is reflected on the watermark flags in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fwft_mode | input | 1 | 0 = standard read, 1 = fall-through read |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| rd_en | input | 1 | Read request (pop acknowledge in fall-through mode) |
| rd_data | output | DW | Read word |
| rd_valid | output | 1 | rd_data carries a word |
| af_level | input | CW | Almost-full distance from DEPTH |
| ae_level | input | CW | Almost-empty occupancy limit |
| full | output | 1 | DEPTH words stored |
| empty | output | 1 | No word stored |
| almost_full | output | 1 | Occupancy + af_level >= DEPTH |
| almost_empty | output | 1 | Occupancy <= ae_level |

## Verification
A wrong occupancy count shows on the four flags in the same cycle. Whenever a watermark level sits near the current fill, the error is visible at once through almost_full or almost_empty. A read address that is off by one shows as a wrong word on rd_data: in fall-through mode in the next cycle, in standard mode at the next read pulse. A write address error appears as a wrong or out-of-order word when that slot is read, which can be up to DEPTH words later. A lost or extra valid pulse in standard mode is seen in the cycle after the read decision. That is why the bench compares every output with its queue model on every clock.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;

    // read-side behaviour selected by the mode input
    typedef enum logic {
        RD_STANDARD = 1'b0,
        RD_FALLTHRU = 1'b1
    } rd_mode_e;

    // one-step pointer advance with explicit wrap, valid for any depth
    function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/sfifo_store.sv
`timescale 1ns/1ps
module sfifo_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    // write port: registered; read port: asynchronous, one address
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sfifo_ptrs.sv
`timescale 1ns/1ps
module sfifo_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [CW-1:0] af_level,
    input  logic [CW-1:0] ae_level,
    output logic          wr_acc,
    output logic          rd_acc,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty
);
    import sfifo_pkg::*;

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [CW:0] af_sum;

    always_comb begin
        full   = (st_q.cnt == CW'(DEPTH));
        empty  = (st_q.cnt == '0);
        wr_acc = wr_en && !full;
        rd_acc = rd_en && !empty;

        af_sum       = {1'b0, st_q.cnt} + {1'b0, af_level};
        almost_full  = (af_sum >= (CW+1)'(DEPTH));
        almost_empty = (st_q.cnt <= ae_level);

        st_d = st_q;
        if (wr_acc) begin
            st_d.wptr = AW'(wrap_inc(int'(st_q.wptr), DEPTH));
        end
        if (rd_acc) begin
            st_d.rptr = AW'(wrap_inc(int'(st_q.rptr), DEPTH));
        end
        unique case ({wr_acc, rd_acc})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign waddr = st_q.wptr;
    assign raddr = st_q.rptr;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (empty && !full && almost_empty));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CW'(DEPTH));

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> ($stable(st_q.cnt) && $stable(st_q.wptr)));

    assert_empty_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> ($stable(st_q.cnt) && $stable(st_q.rptr)));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((st_q.cnt == $past(st_q.cnt)) ||
                  (st_q.cnt == $past(st_q.cnt) + 1'b1) ||
                  (st_q.cnt == $past(st_q.cnt) - 1'b1)));

    assert_mid_rw_R9: assert property (@(posedge clk) disable iff (rst)
        (!full && !empty && wr_en && rd_en) |=> $stable(st_q.cnt));

    assert_full_af_R7: assert property (@(posedge clk) disable iff (rst)
        full |-> almost_full);

    assert_empty_ae_R8: assert property (@(posedge clk) disable iff (rst)
        empty |-> almost_empty);

endmodule

// File: rtl/sfifo_head.sv
`timescale 1ns/1ps
module sfifo_head #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft,
    input  logic          rd_acc,
    input  logic          empty,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    import sfifo_pkg::*;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
    } head_state_t;

    head_state_t hs_d, hs_q;
    rd_mode_e    mode;

    always_comb begin
        mode = rd_mode_e'(fwft);
        hs_d = hs_q;
        hs_d.valid = rd_acc;
        if (rd_acc) begin
            hs_d.data = mem_rdata;
        end
        if (rst) begin
            hs_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        hs_q <= hs_d;
    end

    always_comb begin
        if (mode == RD_FALLTHRU) begin
            rd_valid = !empty;
            rd_data  = empty ? '0 : mem_rdata;
        end else begin
            rd_valid = hs_q.valid;
            rd_data  = hs_q.data;
        end
    end

    assert_std_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (!fwft && rd_acc) |=> (fwft || rd_valid));

    assert_std_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!fwft && !rd_acc) |=> (fwft || (!rd_valid && $stable(rd_data))));

    assert_ff_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (fwft && empty) |-> (rd_data == '0));

endmodule

// File: rtl/sfifo_top.sv
`timescale 1ns/1ps
module sfifo_top #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft_mode,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    input  logic [CW-1:0] af_level,
    input  logic [CW-1:0] ae_level,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty
);

    logic          wr_acc;
    logic          rd_acc;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [DW-1:0] mem_rdata;

    sfifo_ptrs #(.DEPTH(DEPTH)) i_ptrs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .af_level     (af_level),
        .ae_level     (ae_level),
        .wr_acc       (wr_acc),
        .rd_acc       (rd_acc),
        .waddr        (waddr),
        .raddr        (raddr),
        .full         (full),
        .empty        (empty),
        .almost_full  (almost_full),
        .almost_empty (almost_empty)
    );

    sfifo_store #(.DW(DW), .DEPTH(DEPTH)) i_store (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    sfifo_head #(.DW(DW)) i_head (
        .clk       (clk),
        .rst       (rst),
        .fwft      (fwft_mode),
        .rd_acc    (rd_acc),
        .empty     (empty),
        .mem_rdata (mem_rdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: tb/test_sfifo_top.sv
`timescale 1ns/1ps
module test_sfifo_top;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fwft_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [CW-1:0] af_level = CW'(2);
    logic [CW-1:0] ae_level = CW'(2);
    logic          full, empty, almost_full, almost_empty;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    string phase = "init";

    // behavioural model
    int q[$];
    int std_data  = 0;
    bit std_valid = 1'b0;
    int seed = 32'h1234_5678;
    int wval = 1;

    always #2 clk = ~clk;

    sfifo_top #(.DW(DW), .DEPTH(DEPTH)) i_sfifo_top (
        .clk(clk), .rst(rst), .fwft_mode(fwft_mode),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .af_level(af_level), .ae_level(ae_level),
        .full(full), .empty(empty),
        .almost_full(almost_full), .almost_empty(almost_empty)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s [%s] at %0t: actual=%0h expected=%0h", tag, phase, $time, act, exp);
        end
    endtask

    task automatic compare();
        int n = q.size();
        chk("full R3", int'(full), int'(n == DEPTH));
        chk("empty R4", int'(empty), int'(n == 0));
        chk("almost_full R7", int'(almost_full), int'(n + int'(af_level) >= DEPTH));
        chk("almost_empty R8", int'(almost_empty), int'(n <= int'(ae_level)));
        if (fwft_mode) begin
            chk("rd_valid R6", int'(rd_valid), int'(n > 0));
            chk("rd_data R6 R2", int'(rd_data), (n > 0) ? q[0] : 0);
        end else begin
            chk("rd_valid R5", int'(rd_valid), int'(std_valid));
            chk("rd_data R5 R2", int'(rd_data), std_data);
        end
    endtask

    // drive one cycle just after a falling edge, update the model, check at next falling edge
    task automatic cyc(input bit w, input bit r);
        bit rd_ok, wr_ok;
        wr_en   = w;
        rd_en   = r;
        wr_data = DW'(wval);
        if (rst) begin
            q.delete();
            std_data  = 0;
            std_valid = 1'b0;
        end else begin
            rd_ok = r && (q.size() != 0);
            wr_ok = w && (q.size() != DEPTH);
            std_valid = rd_ok;
            if (rd_ok) std_data = q.pop_front();
            if (wr_ok) q.push_back(wval);
        end
        if (w) wval = (wval * 7 + 13) & 16'hFFFF;
        @(negedge clk);
        compare();
    endtask

    function automatic int rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        return seed & 32'h7FFF_FFFF;
    endfunction

    task automatic do_reset(input bit mode);
        rst = 1'b1;
        fwft_mode = mode;
        cyc(0, 0);
        cyc(0, 0);
        rst = 1'b0;
        phase = "R1 reset";
        chk("R1 empty", int'(empty), 1);
        chk("R1 almost_empty", int'(almost_empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 rd_data", int'(rd_data), 0);
    endtask

    task automatic traffic(input int cycles, input int wpct, input int rpct);
        for (int i = 0; i < cycles; i++) begin
            cyc((rnd() % 100) < wpct, (rnd() % 100) < rpct);
        end
    endtask

    initial begin
        @(negedge clk);
        // ---------------- standard mode ----------------
        do_reset(1'b0);
        phase = "R4 read empty";
        cyc(0, 1);
        cyc(0, 1);
        phase = "R5 latency";
        for (int i = 0; i < 5; i++) cyc(1, 0);
        for (int i = 0; i < 5; i++) begin
            cyc(0, 1);
            cyc(0, 0);
        end
        cyc(0, 1);
        phase = "R9 mid rw";
        cyc(1, 0);
        cyc(1, 0);
        for (int i = 0; i < 4; i++) cyc(1, 1);
        phase = "R3 overfill";
        for (int i = 0; i < DEPTH + 3; i++) cyc(1, 0);
        phase = "R10 thresholds";
        af_level = CW'(0);
        @(negedge clk);
        compare();
        af_level = CW'(DEPTH);
        ae_level = CW'(DEPTH);
        #0.1;
        compare();
        phase = "R9 full rw";
        cyc(1, 1);
        cyc(1, 1);
        phase = "R7 drain";
        af_level = CW'(3);
        ae_level = CW'(0);
        for (int i = 0; i < DEPTH + 2; i++) cyc(0, 1);
        phase = "R9 empty rw";
        cyc(1, 1);
        cyc(0, 0);
        phase = "R8 extreme";
        af_level = {CW{1'b1}};
        ae_level = CW'(1);
        cyc(0, 0);
        phase = "R2 random std";
        af_level = CW'(4);
        ae_level = CW'(3);
        traffic(600, 60, 40);
        traffic(600, 40, 60);
        traffic(300, 50, 50);
        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        phase = "R6 first word";
        cyc(1, 0);
        chk("R6 shown without read", int'(rd_valid), 1);
        cyc(0, 0);
        cyc(1, 0);
        cyc(0, 1);
        cyc(0, 1);
        phase = "R4 ff read empty";
        cyc(0, 1);
        phase = "R3 ff overfill";
        for (int i = 0; i < DEPTH + 2; i++) cyc(1, 0);
        cyc(1, 1);
        phase = "R2 random ff";
        af_level = CW'(5);
        ae_level = CW'(5);
        traffic(600, 60, 40);
        traffic(600, 40, 60);
        traffic(300, 50, 50);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule